// File: doc/BRIEF.md
# Audio Transmit FIFO Register Block

This block is the memory-mapped front end of an audio transmit path. Software writes 32-bit sample words into a word FIFO through a data register. A downstream serializer takes words from the head of that FIFO and takes its format settings from the exported configuration fields. Each stereo frame is two consecutive pushes. The block itself does no serial timing and no clock generation.

Two status conditions come from the FIFO fill count. One is set while the FIFO is empty. The other is set while the fill count is below a trigger. The trigger is the FIFO depth shifted right by a 4-bit level field. Each status bit is sticky: once set, it holds until software writes 1 to clear it, and it sets again at once if its condition still holds. The interrupt line is the OR of the status bits that are unmasked, and it is gated by an enable bit in the configuration register.

The register window holds eight 32-bit words at a 4-byte stride, selected by byte-address bits 4:2:
- 0 is the version register.
- 1 is the configuration register.
- 2 is the mask register.
- 3 is the status register.
- 4 to 7 are the data registers.

Top module: `audio_tx_regs`

## Requirements
- R1: While reset is held low at a clock edge, the block returns to its idle state. In that state the configuration and mask registers are zero, read data is zero, the interrupt is low and the FIFO is empty.
- R2: A read of word 0 returns the VERSION parameter. A write to word 0 has no effect.
- R3: Word 1 is the configuration register, and it reads back what was written with the reserved bits 23:22 and 7:3 forced to zero. The fields are: bit 0 transmit enable, bit 1 interrupt enable, bit 2 left-first, bits 15:8 ratio, bits 21:16 resolution, bits 27:24 level and bits 31:28 channel. Each field drives its own output port.
- R4: Word 2 is the mask register. It stores bits 1:0 (bit 0 for underrun, bit 1 for low level), and reads return zero in bits 31:2.
- R5: Each write to word 4 pushes the write data into the FIFO. fifo_head shows the oldest word, fifo_pop removes it, and words leave in the order they were written. Writes to words 5, 6 and 7 push nothing. Reads of words 4 to 7 return zero.
- R6: A push into a full FIFO (DEPTH words) is dropped. The words already stored are left unchanged.
- R7: A pop while the FIFO is empty has no effect.
- R8: Status bit 0 (underrun) is set at each clock edge where the FIFO is empty.
- R9: Status bit 1 (low level) is set at each clock edge where the fill count is below DEPTH >> level. For example, level 1 gives half the depth, and a level of log2(DEPTH)+1 or more never sets the bit.
- R10: A write of 1 to a bit of word 3 clears that status bit. In the same edge, the bit is set again if its condition still holds.
- R11: irq equals interrupt enable AND (OR over the status bits ANDed with the mask bits).
- R12: Read data is registered. bus_rdata shows the addressed register as it was at the read edge, from just after that edge until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_irq_en | output | 1 | Interrupt enable field |
| cfg_left_first | output | 1 | Left-first field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_level | output | 4 | Trigger level field |
| cfg_chan | output | 4 | Channel field |
| fifo_pop | input | 1 | Serializer takes the head word |
| fifo_head | output | 32 | Oldest FIFO word |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
The results of an access fall due at different clock edges:
- Configuration fields, the mask, fifo_head and fifo_empty change at the edge that performs the write or pop.
- Read data is due just after the read edge.
- Status bits follow the FIFO count one edge later, because they are computed from the count held before that edge.
- irq follows status, configuration and mask with no added register.

The bench keeps a reference model that it updates once per rising edge, in the same order as the hardware: read capture, then the status update from the old count, then register and FIFO updates. It compares every output at the following falling edge.

// File: rtl/audio_tx_pkg.sv
// Shared types and constants for the audio transmit register block.
// Assumes a 32-bit register window of eight words at a 4-byte stride.
package audio_tx_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_STAT = 2;
    localparam int STAT_UND = 0;
    localparam int STAT_LOW = 1;
    localparam int IDX_LSB  = 2;
    localparam int IDX_W    = 3;

    // Writable bits of the configuration word; reserved bits read zero
    localparam logic [DATA_W-1:0] CFG_WMASK = 32'hFF3F_FF07;

    typedef enum logic [IDX_W-1:0] {
        IDX_VER  = 3'd0,
        IDX_CFG  = 3'd1,
        IDX_MASK = 3'd2,
        IDX_STAT = 3'd3,
        IDX_CH0  = 3'd4,
        IDX_CH1  = 3'd5,
        IDX_CH2  = 3'd6,
        IDX_CH3  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [3:0] chan;
        logic [3:0] level;
        logic [1:0] rsv_hi;
        logic [5:0] res;
        logic [7:0] ratio;
        logic [4:0] rsv_lo;
        logic       left_first;
        logic       irq_en;
        logic       tx_en;
    } cfg_t;

endpackage

// File: rtl/atx_sample_fifo.sv
// Word FIFO between software pushes and serializer pops.
// Shows the head word combinationally; push when full and pop when empty
// are dropped. Assumes DEPTH >= 2.
module atx_sample_fifo #(
    parameter int DEPTH = 2048,
    parameter int W     = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int              PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted word at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == FULL_CNT));

    // R7
    empty_pop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/atx_status_irq.sv
// Sticky status bits (empty, below trigger) and the interrupt gate.
// Conditions are sampled from the pre-edge fill count; write-1 clears
// lose to a condition that still holds.
module atx_status_irq
    import audio_tx_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    count,
    input  logic [3:0]          level,
    input  logic [NUM_STAT-1:0] clr,
    input  logic [NUM_STAT-1:0] mask,
    input  logic                irq_en,
    output logic [NUM_STAT-1:0] status,
    output logic                irq
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0]    trig;
    logic [NUM_STAT-1:0] cond;

    // Trigger is the depth divided by a power of two
    assign trig           = DEPTH_C >> level;
    assign cond[STAT_UND] = (count == '0);
    assign cond[STAT_LOW] = (count < trig);

    for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
        // Latch each condition until software clears it
        always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] && !clr[i]) || cond[i];
        end
    end

    // Enabled, unmasked status raises the interrupt
    assign irq = irq_en && |(status & mask);

    // R8
    empty_sets_und_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> status[STAT_UND]);

    // R10
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[STAT_UND] && count != '0) |=> !status[STAT_UND]);

endmodule

// File: rtl/atx_reg_bank.sv
// Register decode: version, configuration, mask, status, data words.
// Produces FIFO push and status clear strobes; read data is registered.
module atx_reg_bank
    import audio_tx_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0004
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                wr,
    input  reg_idx_e            idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_STAT-1:0] status,
    output cfg_t                cfg,
    output logic [NUM_STAT-1:0] mask,
    output logic [DATA_W-1:0]   rdata,
    output logic                push,
    output logic [NUM_STAT-1:0] clr
);
    logic wr_hit, rd_hit;
    logic [DATA_W-1:0] rd_mux;

    assign wr_hit = sel && wr;
    assign rd_hit = sel && !wr;
    assign push   = wr_hit && (idx == IDX_CH0);
    assign clr    = (wr_hit && idx == IDX_STAT) ? wdata[NUM_STAT-1:0] : '0;

    // Hold configuration and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= '0;
            mask <= '0;
        end else if (wr_hit) begin
            if (idx == IDX_CFG)  cfg  <= cfg_t'(wdata & CFG_WMASK);
            if (idx == IDX_MASK) mask <= wdata[NUM_STAT-1:0];
        end
    end

    // Select the word being read
    always_comb begin
        case (idx)
            IDX_VER:  rd_mux = VERSION;
            IDX_CFG:  rd_mux = cfg;
            IDX_MASK: rd_mux = {{(DATA_W-NUM_STAT){1'b0}}, mask};
            IDX_STAT: rd_mux = {{(DATA_W-NUM_STAT){1'b0}}, status};
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data on a read access
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_hit) rdata <= rd_mux;
    end

    // R2
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && idx == IDX_VER) |=> (rdata == VERSION));

    // R4
    mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && idx == IDX_MASK) |=> (rdata[DATA_W-1:NUM_STAT] == '0));

endmodule

// File: rtl/audio_tx_regs.sv
// Top of the audio transmit register block: decode, word FIFO, status and
// interrupt. Configuration fields and the FIFO head go to a serializer.
// Assumes ADDR_W >= 5; byte-address bits 1:0 are not decoded.
module audio_tx_regs
    import audio_tx_pkg::*;
#(
    parameter int                DEPTH   = 2048,
    parameter int                ADDR_W  = 5,
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              cfg_tx_en,
    output logic              cfg_irq_en,
    output logic              cfg_left_first,
    output logic [7:0]        cfg_ratio,
    output logic [5:0]        cfg_res,
    output logic [3:0]        cfg_level,
    output logic [3:0]        cfg_chan,
    input  logic              fifo_pop,
    output logic [DATA_W-1:0] fifo_head,
    output logic              fifo_empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cfg_t                cfg;
    reg_idx_e            idx;
    logic [NUM_STAT-1:0] mask, status, clr;
    logic                push, full;
    logic [CNT_W-1:0]    count;
    logic                unused_bits;

    assign idx         = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
    assign unused_bits = ^{bus_addr[IDX_LSB-1:0], bus_addr[ADDR_W-1:IDX_LSB+IDX_W],
                           cfg.rsv_hi, cfg.rsv_lo, full};

    atx_reg_bank #(.VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .idx(idx),
        .wdata(bus_wdata), .status(status), .cfg(cfg), .mask(mask),
        .rdata(bus_rdata), .push(push), .clr(clr)
    );

    atx_sample_fifo #(.DEPTH(DEPTH), .W(DATA_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(fifo_pop),
        .wdata(bus_wdata), .head(fifo_head), .empty(fifo_empty),
        .full(full), .count(count)
    );

    atx_status_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .count(count), .level(cfg.level),
        .clr(clr), .mask(mask), .irq_en(cfg.irq_en), .status(status),
        .irq(irq)
    );

    assign cfg_tx_en      = cfg.tx_en;
    assign cfg_irq_en     = cfg.irq_en;
    assign cfg_left_first = cfg.left_first;
    assign cfg_ratio      = cfg.ratio;
    assign cfg_res        = cfg.res;
    assign cfg_level      = cfg.level;
    assign cfg_chan       = cfg.chan;

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_irq_en);

endmodule

// File: tb/audio_tx_regs_test.sv
module audio_tx_regs_test;
    localparam int          DEPTH = 16;
    localparam logic [31:0] VER   = 32'h5A17_0003;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, fifo_pop = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, fifo_head;
    logic        irq, fifo_empty;
    logic        cfg_tx_en, cfg_irq_en, cfg_left_first;
    logic [7:0]  cfg_ratio;
    logic [5:0]  cfg_res;
    logic [3:0]  cfg_level, cfg_chan;

    audio_tx_regs #(.DEPTH(DEPTH), .ADDR_W(5), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cfg_tx_en(cfg_tx_en), .cfg_irq_en(cfg_irq_en),
        .cfg_left_first(cfg_left_first), .cfg_ratio(cfg_ratio),
        .cfg_res(cfg_res), .cfg_level(cfg_level), .cfg_chan(cfg_chan),
        .fifo_pop(fifo_pop), .fifo_head(fifo_head), .fifo_empty(fifo_empty)
    );

    always #10 clk = ~clk;

    // Reference model state
    logic [31:0] m_cfg = '0, m_rd = '0;
    logic [1:0]  m_mask = '0, m_lat = '0;
    logic [31:0] m_q[$];
    int          vec = 0, bad = 0;
    bit          done = 1'b0;
    string       head_tag = "R5";

    function automatic int thr_of(input logic [3:0] lv);
        return DEPTH >> lv;
    endfunction

    function automatic logic [1:0] cond_of(input int cnt, input logic [3:0] lv);
        return {cnt < thr_of(lv), cnt == 0};
    endfunction

    function automatic logic [31:0] read_of(input logic [2:0] idx);
        case (idx)
            3'd0:    return VER;
            3'd1:    return m_cfg;
            3'd2:    return {30'b0, m_mask};
            3'd3:    return {30'b0, m_lat};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] idx);
        case (idx)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R10";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [31:0] cfg_ports();
        return {cfg_chan, cfg_level, 2'b00, cfg_res, cfg_ratio, 5'b0,
                cfg_left_first, cfg_irq_en, cfg_tx_en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, model at rising edge, check at next fall
    task automatic step(input logic sel, input logic wr, input logic [4:0] addr,
                        input logic [31:0] wd, input logic pop);
        logic [2:0] idx;
        logic [1:0] clr;
        int         cnt;
        bit         push_ok;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd; fifo_pop = pop;
        @(posedge clk);
        idx = addr[4:2];
        cnt = m_q.size();
        if (sel && !wr) m_rd = read_of(idx);
        clr = (sel && wr && idx == 3'd3) ? wd[1:0] : 2'b00;
        m_lat = (m_lat & ~clr) | cond_of(cnt, m_cfg[27:24]);
        if (sel && wr && idx == 3'd1) m_cfg = wd & 32'hFF3F_FF07;
        if (sel && wr && idx == 3'd2) m_mask = wd[1:0];
        push_ok = sel && wr && idx == 3'd4 && cnt < DEPTH;
        if (pop && cnt > 0) void'(m_q.pop_front());
        if (push_ok) m_q.push_back(wd);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; fifo_pop = 1'b0;
        chk("R11", {31'b0, irq}, {31'b0, m_cfg[1] & |(m_lat & m_mask)});
        chk("R5", {31'b0, fifo_empty}, {31'b0, m_q.size() == 0});
        if (m_q.size() > 0) chk(head_tag, fifo_head, m_q[0]);
        if (sel && !wr) chk(rd_tag(idx), bus_rdata, m_rd);
        if (sel && wr && idx == 3'd1) chk("R3", cfg_ports(), m_cfg);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd_reg(input logic [4:0] a);
        step(1'b1, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 5'h0, 32'h0, 1'b0);
    endtask

    task automatic pop1();
        step(1'b0, 1'b0, 5'h0, 32'h0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", bus_rdata, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);
        chk("R1", {31'b0, fifo_empty}, 32'h1);
        chk("R1", cfg_ports(), 32'h0);
        rst_n = 1'b1;

        // R2 version read, ignored write, R12 read latency
        rd_reg(5'h00);
        chk("R12", bus_rdata, VER);
        wr_reg(5'h00, 32'hFFFF_FFFF);
        rd_reg(5'h00);
        // R8 / R9 from reset: empty and below trigger
        rd_reg(5'h0C);
        chk("R8", {31'b0, bus_rdata[0]}, 32'h1);
        chk("R9", {31'b0, bus_rdata[1]}, 32'h1);

        // R3 configuration with reserved bits set: level 1, interrupt enable
        wr_reg(5'h04, 32'hF1AB_FFFA);
        rd_reg(5'h04);
        chk("R3", bus_rdata, 32'hF12B_FF02);
        // R4 mask keeps two bits
        wr_reg(5'h08, 32'hFFFF_FFFF);
        rd_reg(5'h08);
        chk("R4", bus_rdata, 32'h3);
        chk("R11", {31'b0, irq}, 32'h1);

        // R5 other data words push nothing
        wr_reg(5'h14, 32'h1111_1111);
        wr_reg(5'h18, 32'h2222_2222);
        wr_reg(5'h1C, 32'h3333_3333);
        rd_reg(5'h10);
        chk("R5", {31'b0, fifo_empty}, 32'h1);

        // Fill to the trigger (8 of 16), clear, expect status 0
        for (int i = 0; i < 8; i++) wr_reg(5'h10, 32'hA000_0000 + i);
        idle();
        wr_reg(5'h0C, 32'h3);
        rd_reg(5'h0C);
        chk("R10", bus_rdata, 32'h0);
        chk("R11", {31'b0, irq}, 32'h0);
        // One below the trigger: low-level bit returns and survives a clear
        pop1();
        idle();
        rd_reg(5'h0C);
        chk("R9", bus_rdata, 32'h2);
        wr_reg(5'h0C, 32'h2);
        rd_reg(5'h0C);
        chk("R10", bus_rdata, 32'h2);
        wr_reg(5'h08, 32'h1);
        chk("R11", {31'b0, irq}, 32'h0);

        // R6 overfill then drain in order
        head_tag = "R6";
        for (int i = 0; i < 13; i++) wr_reg(5'h10, 32'hB000_0000 + i);
        for (int i = 0; i < DEPTH; i++) pop1();
        chk("R6", {31'b0, fifo_empty}, 32'h1);

        // R7 pops on empty are ignored
        head_tag = "R7";
        pop1(); pop1(); pop1();
        wr_reg(5'h10, 32'hC0DE_0001);
        chk("R7", fifo_head, 32'hC0DE_0001);
        pop1();
        head_tag = "R5";

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            r = $urandom_range(0, 99);
            if (r < 35)
                step(1'b1, 1'b1, 5'h10, $urandom, ($urandom_range(0, 3) == 0));
            else if (r < 60) pop1();
            else if (r < 70) rd_reg(5'($urandom_range(0, 31)));
            else if (r < 78) wr_reg(5'h0C, $urandom);
            else if (r < 82) begin
                logic [31:0] w;
                w = $urandom;
                w[27:24] = 4'($urandom_range(0, 5));
                wr_reg(5'h04, w);
            end
            else if (r < 86) wr_reg(5'h08, $urandom);
            else if (r < 90) begin
                int k;
                k = $urandom_range(0, 3);
                wr_reg((k == 0) ? 5'h00 : 5'(16 + 4 * k), $urandom);
            end
            else idle();
        end
        finish_run();
    end
endmodule